// File: doc/BRIEF.md
# DMA Completion Push Notifier

This block turns DMA channel completions into addressed status pushes. Each DMA channel in the group raises a done flag when its transfer ends. Software, acting for the engine that owns the channel, first fills in a per-channel target word. That word names the destination engine, the hardware context, the register and the signal to raise. When a done flag rises and the channel is enabled for notification, the block queues one push for that channel. It then requests the shared push bus and, once granted, drives a push ID built from the target word together with a small status word (done, error, channel index).

The block also keeps a mirror of every channel's done flag, for software to poll. If several channels finish in the same cycle, their pushes leave one per grant, lowest channel index first. A done flag that software clears before the grant arrives cancels the pending push for that channel, so no stale status reaches the engine.

Top module: `dma_push_notify`

## Requirements
- R1: `done_status_o` equals `ch_done_i` as sampled at the previous rising clock edge.
- R2: A rising edge on `ch_done_i[c]` while `push_en_i[c]` is 1 makes `push_req_o` 1 from the next cycle on.
- R3: A rising edge on `ch_done_i[c]` while `push_en_i[c]` is 0 queues nothing: no request and no push for that event, even if the enable is set afterwards.
- R4: While no grant arrives, a queued push whose done flag stays high keeps `push_req_o` at 1 and produces no `push_valid_o`.
- R5: A cycle with `push_req_o` and `push_gnt_i` both 1 is followed by exactly one cycle of `push_valid_o`. In that cycle `push_id_o` equals the channel's 16-bit target word, packed as engine [15:12], context [11:9], register [8:4], signal [3:0].
- R6: The status word `push_data_o` has bit 0 set to the error flag sampled with the done rising edge, bit 1 set to 1, bits 3:2 holding the channel index, and every higher bit at 0.
- R7: When several channels are queued, each grant serves the lowest-indexed one that is still queued.
- R8: Each done rising edge produces at most one push. A done flag that stays high after its push queues nothing further.
- R9: Clearing `ch_done_i[c]` before the grant cancels the queued push for channel c. With no other channel queued, `push_req_o` falls in the same cycle.
- R10: During and right after reset, `push_req_o`, `push_valid_o` and `done_status_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_done_i | input | NUM_CH | Per-channel done flag from the DMA engine (cleared by software) |
| ch_err_i | input | NUM_CH | Per-channel error flag, valid when done rises |
| push_en_i | input | NUM_CH | Per-channel notification enable |
| ch_param_i | input | NUM_CH*16 | Per-channel target words, channel c at bits [16c+15:16c] |
| done_status_o | output | NUM_CH | Registered mirror of the done flags |
| push_req_o | output | 1 | Request for the shared push bus |
| push_gnt_i | input | 1 | Grant from the push bus arbiter |
| push_valid_o | output | 1 | Push beat valid |
| push_id_o | output | 16 | Push destination ID |
| push_data_o | output | DATA_W | Completion status word |

## Verification
A queue bit that is wrongly set or wrongly kept shows up at the ports as a push the scoreboard did not expect. This happens on the first grant after the fault, which comes a cycle or two after the done edge. A lost queue bit leaves `push_req_o` low where the bench expects it high in the cycle after the done edge. An error in the priority pick or in the operand mux shows as a mismatch in `push_id_o` or in the channel index field of `push_data_o` on the very push it affects. A faulty mirror register is caught one cycle after any change of a done flag.

// File: rtl/dpn_pkg.sv
package dpn_pkg;

  localparam int ENG_W = 4;
  localparam int CTX_W = 3;
  localparam int REG_W = 5;
  localparam int SIG_W = 4;
  localparam int ID_W  = ENG_W + CTX_W + REG_W + SIG_W;
  localparam int IDX_W = 2;
  localparam int CODE_W = 2 + IDX_W;

  typedef struct packed {
    logic [ENG_W-1:0] eng;
    logic [CTX_W-1:0] ctx;
    logic [REG_W-1:0] regn;
    logic [SIG_W-1:0] sig;
  } push_tgt_t;

  function automatic logic [ID_W-1:0] make_push_id(input push_tgt_t t);
    return {t.eng, t.ctx, t.regn, t.sig};
  endfunction

  function automatic logic [CODE_W-1:0] make_status(input logic [IDX_W-1:0] idx,
                                                     input logic err);
    return {idx, 1'b1, err};
  endfunction

endpackage

// File: rtl/dpn_done_track.sv
module dpn_done_track #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic [NUM_CH-1:0] ch_err_i,
  input  logic [NUM_CH-1:0] push_en_i,
  input  logic              grant_fire,
  input  logic [NUM_CH-1:0] sel_onehot,
  output logic [NUM_CH-1:0] done_q,
  output logic [NUM_CH-1:0] pend_q,
  output logic [NUM_CH-1:0] err_q,
  output logic [NUM_CH-1:0] pend_live,
  output logic [NUM_CH-1:0] done_rise
);

  assign done_rise = ch_done_i & ~done_q;
  assign pend_live = pend_q & ch_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= ch_done_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic served;
    assign served = grant_fire & sel_onehot[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[c] <= 1'b0;
        err_q[c]  <= 1'b0;
      end else if (done_rise[c]) begin
        pend_q[c] <= push_en_i[c];
        err_q[c]  <= ch_err_i[c];
      end else begin
        pend_q[c] <= pend_live[c] & ~served;
      end
    end
  end

endmodule

// File: rtl/dpn_prio_pick.sv
module dpn_prio_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0]          req_vec,
  output logic [NUM_CH-1:0]          sel_onehot,
  output logic [dpn_pkg::IDX_W-1:0]  sel_idx,
  output logic                       any
);

  always_comb begin
    sel_onehot = '0;
    sel_idx    = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        sel_onehot    = '0;
        sel_onehot[i] = 1'b1;
        sel_idx       = dpn_pkg::IDX_W'(i);
      end
    end
  end

  assign any = |req_vec;

endmodule

// File: rtl/dpn_push_drive.sv
module dpn_push_drive #(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      grant_fire,
  input  dpn_pkg::push_tgt_t        sel_tgt,
  input  logic [dpn_pkg::IDX_W-1:0] sel_idx,
  input  logic                      sel_err,
  output logic                      push_valid_o,
  output logic [dpn_pkg::ID_W-1:0]  push_id_o,
  output logic [DATA_W-1:0]         push_data_o
);
  import dpn_pkg::*;

  localparam int PAD_W = DATA_W - CODE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_valid_o <= 1'b0;
      push_id_o    <= '0;
      push_data_o  <= '0;
    end else begin
      push_valid_o <= grant_fire;
      if (grant_fire) begin
        push_id_o   <= make_push_id(sel_tgt);
        push_data_o <= {{PAD_W{1'b0}}, make_status(sel_idx, sel_err)};
      end
    end
  end

endmodule

// File: rtl/dma_push_notify.sv
module dma_push_notify #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             ch_done_i,
  input  logic [NUM_CH-1:0]             ch_err_i,
  input  logic [NUM_CH-1:0]             push_en_i,
  input  logic [NUM_CH*dpn_pkg::ID_W-1:0] ch_param_i,
  output logic [NUM_CH-1:0]             done_status_o,
  output logic                          push_req_o,
  input  logic                          push_gnt_i,
  output logic                          push_valid_o,
  output logic [dpn_pkg::ID_W-1:0]      push_id_o,
  output logic [DATA_W-1:0]             push_data_o
);
  import dpn_pkg::*;

  logic [NUM_CH-1:0] done_q, pend_q, err_q, pend_live, done_rise, sel_onehot;
  logic [IDX_W-1:0]  sel_idx;
  logic              any_live, grant_fire, sel_err;
  push_tgt_t         sel_tgt;
  push_tgt_t         tgt_arr [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
    assign tgt_arr[c] = push_tgt_t'(ch_param_i[c*ID_W +: ID_W]);
  end

  dpn_done_track #(.NUM_CH(NUM_CH)) u_track (
    .clk(clk), .rst_n(rst_n),
    .ch_done_i(ch_done_i), .ch_err_i(ch_err_i), .push_en_i(push_en_i),
    .grant_fire(grant_fire), .sel_onehot(sel_onehot),
    .done_q(done_q), .pend_q(pend_q), .err_q(err_q),
    .pend_live(pend_live), .done_rise(done_rise)
  );

  dpn_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req_vec(pend_live), .sel_onehot(sel_onehot),
    .sel_idx(sel_idx), .any(any_live)
  );

  always_comb begin
    sel_tgt = '0;
    sel_err = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_onehot[i]) begin
        sel_tgt = sel_tgt | tgt_arr[i];
        sel_err = sel_err | err_q[i];
      end
    end
  end

  assign push_req_o    = any_live;
  assign grant_fire    = any_live & push_gnt_i;
  assign done_status_o = done_q;

  dpn_push_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .grant_fire(grant_fire),
    .sel_tgt(sel_tgt), .sel_idx(sel_idx), .sel_err(sel_err),
    .push_valid_o(push_valid_o), .push_id_o(push_id_o), .push_data_o(push_data_o)
  );

endmodule

// File: rtl/dpn_checker.sv
module dpn_checker #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_req_o,
  input logic              push_gnt_i,
  input logic              push_valid_o,
  input logic [DATA_W-1:0] push_data_o,
  input logic [NUM_CH-1:0] ch_done_i,
  input logic [NUM_CH-1:0] pend_q,
  input logic [NUM_CH-1:0] pend_live,
  input logic [NUM_CH-1:0] sel_onehot,
  input logic              grant_fire
);

  assert_valid_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o |-> $past(push_req_o && push_gnt_i));

  assert_hold_without_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req_o && !push_gnt_i) |=>
      ((pend_q & $past(pend_q & ch_done_i)) == $past(pend_q & ch_done_i)));

  assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> ($countones(sel_onehot) == 1 &&
                    (pend_live & (sel_onehot - 1'b1)) == '0));

  assert_status_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o |-> (push_data_o[1] && (push_data_o >> 4) == '0));

  assert_cancel_drops_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done_i == '0) |-> !push_req_o);

endmodule

bind dma_push_notify dpn_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_req_o(push_req_o), .push_gnt_i(push_gnt_i),
  .push_valid_o(push_valid_o), .push_data_o(push_data_o), .ch_done_i(ch_done_i),
  .pend_q(pend_q), .pend_live(pend_live), .sel_onehot(sel_onehot),
  .grant_fire(grant_fire)
);

// File: tb/sim_dma_push_notify.sv
`timescale 1ns/1ps
module sim_dma_push_notify;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] ch_done = '0, ch_err = '0, push_en = '1;
  logic [NUM_CH*16-1:0] ch_param;
  logic [NUM_CH-1:0] done_status;
  logic push_req, push_gnt = 1'b0, push_valid;
  logic [15:0] push_id;
  logic [DATA_W-1:0] push_data;

  int checks = 0, errors = 0;
  logic [47:0] expq [$];

  always #2.5 clk = ~clk;

  dma_push_notify #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_done_i(ch_done), .ch_err_i(ch_err),
    .push_en_i(push_en), .ch_param_i(ch_param), .done_status_o(done_status),
    .push_req_o(push_req), .push_gnt_i(push_gnt), .push_valid_o(push_valid),
    .push_id_o(push_id), .push_data_o(push_data)
  );

  function automatic logic [15:0] exp_id(int c);
    int eng = c + 3, ctx = (c * 3) % 8, rg = (c * 7 + 5) % 32, sg = 15 - c;
    return 16'((eng << 12) + (ctx << 9) + (rg << 4) + sg);
  endfunction

  function automatic logic [31:0] exp_data(int c, bit err);
    return 32'((c << 2) + 2 + (err ? 1 : 0));
  endfunction

  initial for (int c = 0; c < NUM_CH; c++) ch_param[c*16 +: 16] = exp_id(c);

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_push(int c, bit err);
    expq.push_back({exp_id(c), exp_data(c, err)});
  endtask

  task automatic grant(int n);
    push_gnt = 1'b1;
    cyc(n);
    push_gnt = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && push_valid) begin
      if (expq.size() == 0) begin
        check("R8 unexpected push", {push_id, push_data}, 48'h0);
      end else begin
        logic [47:0] e;
        e = expq.pop_front();
        check("R5 push id", 48'(push_id), 48'(e[47:32]));
        check("R6 status word", 48'(push_data), 48'(e[31:0]));
      end
    end
  end

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", wd);
        finish_run();
      end
    end
  end

  initial begin
    cyc(3);
    check("R10 req in reset", 48'(push_req), 48'h0);
    check("R10 valid in reset", 48'(push_valid), 48'h0);
    rst_n = 1'b1;
    cyc(1);
    check("R10 status after reset", 48'(done_status), 48'h0);
    check("R10 req after reset", 48'(push_req), 48'h0);

    // single completion, held without grant
    ch_done[1] = 1'b1;
    cyc(1);
    check("R1 status mirror", 48'(done_status), 48'h2);
    check("R2 request raised", 48'(push_req), 48'h1);
    cyc(3);
    check("R4 request held", 48'(push_req), 48'h1);
    expect_push(1, 1'b0);
    grant(1);
    cyc(3);
    check("R8 no second request", 48'(push_req), 48'h0);
    ch_done = '0;
    cyc(1);
    check("R1 status cleared", 48'(done_status), 48'h0);

    // error completion
    ch_err[2] = 1'b1; ch_done[2] = 1'b1;
    cyc(1);
    ch_err = '0;
    expect_push(2, 1'b1);
    grant(1);
    cyc(2);
    ch_done = '0;
    cyc(2);

    // simultaneous completions
    ch_done = 4'b1101;
    cyc(1);
    check("R1 status multi", 48'(done_status), 48'hD);
    expect_push(0, 1'b0);
    expect_push(2, 1'b0);
    expect_push(3, 1'b0);
    grant(3);
    check("R7 all served", 48'(push_req), 48'h0);
    cyc(2);
    ch_done = '0;
    cyc(2);

    // disabled channel
    push_en = 4'b1101;
    ch_done[1] = 1'b1;
    cyc(2);
    check("R3 no request when disabled", 48'(push_req), 48'h0);
    push_en = '1;
    cyc(1);
    check("R3 late enable ignored", 48'(push_req), 48'h0);
    grant(2);
    ch_done = '0;
    cyc(2);

    // cancel before grant
    ch_done[3] = 1'b1;
    cyc(2);
    check("R2 request ch3", 48'(push_req), 48'h1);
    ch_done[3] = 1'b0;
    #0.5;
    check("R9 request drops on cancel", 48'(push_req), 48'h0);
    cyc(1);
    grant(2);
    check("R9 still idle", 48'(push_req), 48'h0);
    cyc(3);
    check("R8 scoreboard drained", 48'(expq.size()), 48'h0);
    finish_run();
  end

endmodule